// File: doc/BRIEF.md
# Programmable Asynchronous Memory Controller

This block turns single-word requests from on-chip logic into read and write cycles on an external asynchronous memory port. The port carries four active-low chip enables, a read/not-write line, a 2-bit bank/byte field, a 22-bit word address, a 16-bit bidirectional data bus, separate output and write enables, and a WAIT input from slow devices.

Each chip enable has its own cycle profile. Reads and writes each have their own setup, strobe and hold counts. Each count is a 4-bit field, and a field value of n gives n+1 clock periods. Each chip enable also has two mode bits. The extended-wait bit lets WAIT stretch the strobe. The select-strobe bit limits the chip enable to the strobe window; with the bit clear, the enable spans the whole cycle. The profile is sampled when a request is accepted. The profile inputs are meant to come from registers elsewhere in the chip.

Requests use a valid/ready handshake. Completion is reported by a one-clock `done` pulse, and read data is valid on `rdata` at that pulse. WAIT is assumed to be already synchronous to `clk`.

Top module: `amem_ctrl`

## Requirements
- R1: During and after synchronous active-low reset, all four chip enables, `mem_oe_n` and `mem_we_n` are high, `done` is low and `req_ready` is high.
- R2: On a write, `mem_addr`, `mem_bank`, `mem_rnw` (0 for write) and the write data are valid and stable for exactly WS+1 clock periods before `mem_we_n` falls.
- R3: On a write, `mem_we_n` is low for exactly WST+1 periods when extended wait is off or WAIT stays low. `mem_oe_n` stays high throughout the write.
- R4: After `mem_we_n` rises, address, bank, read/not-write and write data stay valid for exactly WH+1 periods. `done` is high in the period that follows, for that one period only.
- R5: On a read, `mem_rnw` is 1. The address and bank lead the fall of `mem_oe_n` by RS+1 periods. `mem_oe_n` stays low for RST+1 periods, and the address is held for RH+1 periods after it rises. `mem_we_n` stays high.
- R6: Only the chip enable indexed by `req_cs` goes low. With the select-strobe bit at 0, it is low for setup+strobe+hold+3 periods. With the bit at 1, it is low exactly while the active strobe is low.
- R7: With the extended-wait bit at 1, if WAIT is sampled high during the strobe, the strobe ends 4 periods after the first period in which WAIT is sampled low. A strobe with WAIT high for K periods from its first period therefore lasts K+4 periods.
- R8: With the extended-wait bit at 0, WAIT has no effect on strobe length.
- R9: Read data is sampled on the last period of the read strobe. It is presented on `rdata` when `done` pulses and held until the next read.
- R10: The controller drives the data bus with the request's write data through the whole setup, strobe and hold of a write. It releases the bus otherwise, so a following read returns what the memory drives.
- R11: `req_ready` is high only while idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high. A new request may be taken in the same period that `done` is high.
- R12: Timing fields are packed 4 bits per chip enable, chip enable n in bits [4n+3:4n]. The mode bits are one bit per chip enable. Each cycle uses the fields of its own chip enable and direction only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Chip-enable index |
| req_addr | input | 22 | Word address |
| req_bank | input | 2 | Bank/byte field |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |
| cfg_rd_setup | input | 16 | Read setup count per chip enable |
| cfg_rd_strobe | input | 16 | Read strobe count per chip enable |
| cfg_rd_hold | input | 16 | Read hold count per chip enable |
| cfg_wr_setup | input | 16 | Write setup count per chip enable |
| cfg_wr_strobe | input | 16 | Write strobe count per chip enable |
| cfg_wr_hold | input | 16 | Write hold count per chip enable |
| cfg_ext_wait | input | 4 | Extended-wait enable per chip enable |
| cfg_sel_strobe | input | 4 | Select-strobe mode per chip enable |
| mem_ce_n | output | 4 | Active-low chip enables |
| mem_rnw | output | 1 | Read/not-write |
| mem_bank | output | 2 | Bank/byte field |
| mem_addr | output | 22 | Word address |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_data | inout | 16 | Bidirectional data bus |
| mem_wait | input | 1 | Strobe stretch request from the memory |

## Verification
The bench sweeps setup, strobe and hold counts over 0..2 in both directions and in both chip-enable modes, and also runs the all-15 profile. An off-by-one in any phase counter shows up as a setup, strobe or hold length one period off. A select-strobe decode error shows up as a chip enable that spans setup and hold, or that misses the strobe. WAIT runs of several lengths are applied with extended wait on and off. A wrong tail reload gives a strobe that does not end exactly four periods after release, and a missing mode gate lets WAIT stretch a cycle it should not touch. Writes are followed by reads of the same locations at once, on chip enables set to different profiles. A design that captured data at the wrong edge, kept driving the bus, or used another chip enable's fields returns wrong data or wrong phase lengths.

// File: rtl/amem_pkg.sv
// Shared types for the asynchronous memory controller.
// Assumes every timing field has the same width, TIME_W.
package amem_pkg;

    localparam int TIME_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [TIME_W-1:0] setup;
        logic [TIME_W-1:0] strobe;
        logic [TIME_W-1:0] hold;
        logic              ext_wait;
        logic              sel_strobe;
    } timing_t;

endpackage

// File: rtl/amem_cfg_sel.sv
// Picks the timing profile for one cycle from the packed per-chip-enable fields.
// Assumes N_CS is a power of two, so every value of cs names a chip enable.
module amem_cfg_sel
    import amem_pkg::*;
#(
    parameter int N_CS = 4,
    parameter int CS_W = 2
) (
    input  logic [N_CS*TIME_W-1:0] rd_setup,
    input  logic [N_CS*TIME_W-1:0] rd_strobe,
    input  logic [N_CS*TIME_W-1:0] rd_hold,
    input  logic [N_CS*TIME_W-1:0] wr_setup,
    input  logic [N_CS*TIME_W-1:0] wr_strobe,
    input  logic [N_CS*TIME_W-1:0] wr_hold,
    input  logic [N_CS-1:0]        ext_wait,
    input  logic [N_CS-1:0]        sel_strobe,
    input  logic [CS_W-1:0]        cs,
    input  logic                   is_write,
    output timing_t                sel
);

    timing_t rd_tbl [N_CS];
    timing_t wr_tbl [N_CS];

    for (genvar g = 0; g < N_CS; g++) begin : g_prof
        // unpack the read profile of chip enable g
        assign rd_tbl[g].setup      = rd_setup[g*TIME_W +: TIME_W];
        assign rd_tbl[g].strobe     = rd_strobe[g*TIME_W +: TIME_W];
        assign rd_tbl[g].hold       = rd_hold[g*TIME_W +: TIME_W];
        assign rd_tbl[g].ext_wait   = ext_wait[g];
        assign rd_tbl[g].sel_strobe = sel_strobe[g];
        // unpack the write profile of chip enable g
        assign wr_tbl[g].setup      = wr_setup[g*TIME_W +: TIME_W];
        assign wr_tbl[g].strobe     = wr_strobe[g*TIME_W +: TIME_W];
        assign wr_tbl[g].hold       = wr_hold[g*TIME_W +: TIME_W];
        assign wr_tbl[g].ext_wait   = ext_wait[g];
        assign wr_tbl[g].sel_strobe = sel_strobe[g];
    end

    // select the profile of the addressed chip enable and direction
    always_comb begin
        if (is_write) sel = wr_tbl[cs];
        else          sel = rd_tbl[cs];
    end

endmodule

// File: rtl/amem_seq.sv
// Cycle sequencer: idle -> setup -> strobe -> hold -> idle, with one down-counter
// shared by the phases. Latches the request and its profile when it is accepted.
// Assumes mem_wait is already synchronous to clk.
module amem_seq
    import amem_pkg::*;
#(
    parameter int N_CS      = 4,
    parameter int CS_W      = 2,
    parameter int AW        = 22,
    parameter int BW        = 2,
    parameter int DW        = 16,
    parameter int WAIT_TAIL = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [CS_W-1:0] req_cs,
    input  logic [AW-1:0]   req_addr,
    input  logic [BW-1:0]   req_bank,
    input  logic [DW-1:0]   req_wdata,
    input  timing_t         tsel,
    input  logic            mem_wait,
    output logic            req_ready,
    output logic            done,
    output logic            cap_en,
    output phase_e          ph_d,
    output logic            nxt_wr,
    output logic [CS_W-1:0] nxt_cs,
    output logic            nxt_ss,
    output logic            wr_q,
    output logic [AW-1:0]   addr_q,
    output logic [BW-1:0]   bank_q,
    output logic [DW-1:0]   wdata_q
);

    localparam logic [TIME_W-1:0] TAIL_LD = TIME_W'(WAIT_TAIL - 1);

    phase_e            ph_q;
    logic [TIME_W-1:0] cnt_q, cnt_d;
    timing_t           tim_q;
    logic [CS_W-1:0]   cs_q;
    logic              done_q;
    logic              accept;
    logic              stb_last;

    assign accept    = req_valid && (ph_q == PH_IDLE);
    assign req_ready = (ph_q == PH_IDLE);
    assign done      = done_q;
    assign cap_en    = stb_last && !wr_q;
    assign nxt_wr    = accept ? req_write      : wr_q;
    assign nxt_cs    = accept ? req_cs         : cs_q;
    assign nxt_ss    = accept ? tsel.sel_strobe : tim_q.sel_strobe;

    // next phase and counter value
    always_comb begin
        ph_d     = ph_q;
        cnt_d    = cnt_q;
        stb_last = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (accept) begin
                    ph_d  = PH_SETUP;
                    cnt_d = tsel.setup;
                end
            end
            PH_SETUP: begin
                if (cnt_q == '0) begin
                    ph_d  = PH_STROBE;
                    cnt_d = tim_q.strobe;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_STROBE: begin
                if (tim_q.ext_wait && mem_wait) begin
                    cnt_d = TAIL_LD;
                end else if (cnt_q == '0) begin
                    ph_d     = PH_HOLD;
                    cnt_d    = tim_q.hold;
                    stb_last = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_HOLD: begin
                if (cnt_q == '0) ph_d = PH_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // phase, counter and completion pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            done_q <= (ph_q == PH_HOLD) && (cnt_q == '0);
        end
    end

    // request context, captured once per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q   <= '0;
            wr_q    <= 1'b0;
            cs_q    <= '0;
            addr_q  <= '0;
            bank_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            tim_q   <= tsel;
            wr_q    <= req_write;
            cs_q    <= req_cs;
            addr_q  <= req_addr;
            bank_q  <= req_bank;
            wdata_q <= req_wdata;
        end
    end

endmodule

// File: rtl/amem_pins.sv
// Pin stage: registers the chip enables, strobes and bus-drive enable from the
// sequencer's next phase, so the pins come straight from flops; captures read data.
module amem_pins
    import amem_pkg::*;
#(
    parameter int N_CS = 4,
    parameter int CS_W = 2,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  phase_e          ph_d,
    input  logic            nxt_wr,
    input  logic [CS_W-1:0] nxt_cs,
    input  logic            nxt_ss,
    input  logic            cap_en,
    input  logic [DW-1:0]   mem_din,
    output logic [N_CS-1:0] ce_n,
    output logic            oe_n,
    output logic            we_n,
    output logic            drive_en,
    output logic [DW-1:0]   rdata
);

    logic            active;
    logic            in_stb;
    logic [N_CS-1:0] ce_want;

    assign active = (ph_d != PH_IDLE);
    assign in_stb = (ph_d == PH_STROBE);

    for (genvar g = 0; g < N_CS; g++) begin : g_ce
        // enable g is wanted when addressed, over the window its mode selects
        assign ce_want[g] = (nxt_cs == CS_W'(g)) && (nxt_ss ? in_stb : active);
    end

    // control pin registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n     <= '1;
            oe_n     <= 1'b1;
            we_n     <= 1'b1;
            drive_en <= 1'b0;
        end else begin
            ce_n     <= ~ce_want;
            oe_n     <= !(in_stb && !nxt_wr);
            we_n     <= !(in_stb && nxt_wr);
            drive_en <= active && nxt_wr;
        end
    end

    // read data capture on the last strobe period
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (cap_en) rdata <= mem_din;
    end

endmodule

// File: rtl/amem_ctrl.sv
// Top of the asynchronous memory controller: profile select, sequencer and pin
// stage, plus the tri-state driver for the data bus. Each cycle's profile is
// sampled at request acceptance; WAIT must be synchronous to clk.
module amem_ctrl
    import amem_pkg::*;
#(
    parameter int N_CS      = 4,
    parameter int AW        = 22,
    parameter int BW        = 2,
    parameter int DW        = 16,
    parameter int WAIT_TAIL = 4,
    localparam int CS_W     = (N_CS > 1) ? $clog2(N_CS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [CS_W-1:0]        req_cs,
    input  logic [AW-1:0]          req_addr,
    input  logic [BW-1:0]          req_bank,
    input  logic [DW-1:0]          req_wdata,
    output logic                   done,
    output logic [DW-1:0]          rdata,
    input  logic [N_CS*TIME_W-1:0] cfg_rd_setup,
    input  logic [N_CS*TIME_W-1:0] cfg_rd_strobe,
    input  logic [N_CS*TIME_W-1:0] cfg_rd_hold,
    input  logic [N_CS*TIME_W-1:0] cfg_wr_setup,
    input  logic [N_CS*TIME_W-1:0] cfg_wr_strobe,
    input  logic [N_CS*TIME_W-1:0] cfg_wr_hold,
    input  logic [N_CS-1:0]        cfg_ext_wait,
    input  logic [N_CS-1:0]        cfg_sel_strobe,
    output logic [N_CS-1:0]        mem_ce_n,
    output logic                   mem_rnw,
    output logic [BW-1:0]          mem_bank,
    output logic [AW-1:0]          mem_addr,
    output logic                   mem_oe_n,
    output logic                   mem_we_n,
    inout  wire  [DW-1:0]          mem_data,
    input  logic                   mem_wait
);

    timing_t         tsel;
    phase_e          ph_d;
    logic            nxt_wr;
    logic [CS_W-1:0] nxt_cs;
    logic            nxt_ss;
    logic            cap_en;
    logic            wr_q;
    logic [DW-1:0]   wdata_q;
    logic            drive_en;
    logic [DW-1:0]   mem_din;

    amem_cfg_sel #(.N_CS(N_CS), .CS_W(CS_W)) u_sel (
        .rd_setup   (cfg_rd_setup),
        .rd_strobe  (cfg_rd_strobe),
        .rd_hold    (cfg_rd_hold),
        .wr_setup   (cfg_wr_setup),
        .wr_strobe  (cfg_wr_strobe),
        .wr_hold    (cfg_wr_hold),
        .ext_wait   (cfg_ext_wait),
        .sel_strobe (cfg_sel_strobe),
        .cs         (req_cs),
        .is_write   (req_write),
        .sel        (tsel)
    );

    amem_seq #(
        .N_CS(N_CS), .CS_W(CS_W), .AW(AW), .BW(BW), .DW(DW), .WAIT_TAIL(WAIT_TAIL)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .req_bank  (req_bank),
        .req_wdata (req_wdata),
        .tsel      (tsel),
        .mem_wait  (mem_wait),
        .req_ready (req_ready),
        .done      (done),
        .cap_en    (cap_en),
        .ph_d      (ph_d),
        .nxt_wr    (nxt_wr),
        .nxt_cs    (nxt_cs),
        .nxt_ss    (nxt_ss),
        .wr_q      (wr_q),
        .addr_q    (mem_addr),
        .bank_q    (mem_bank),
        .wdata_q   (wdata_q)
    );

    amem_pins #(.N_CS(N_CS), .CS_W(CS_W), .DW(DW)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph_d     (ph_d),
        .nxt_wr   (nxt_wr),
        .nxt_cs   (nxt_cs),
        .nxt_ss   (nxt_ss),
        .cap_en   (cap_en),
        .mem_din  (mem_din),
        .ce_n     (mem_ce_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .drive_en (drive_en),
        .rdata    (rdata)
    );

    assign mem_rnw  = !wr_q;
    assign mem_data = drive_en ? wdata_q : {DW{1'bz}};
    assign mem_din  = mem_data;

endmodule

// File: rtl/amem_ctrl_chk.sv
// Protocol checker for amem_ctrl, attached by bind. Watches the port only.
module amem_ctrl_chk #(
    parameter int N_CS = 4,
    parameter int AW   = 22
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            done,
    input logic [N_CS-1:0] mem_ce_n,
    input logic            mem_rnw,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_oe_n,
    input logic            mem_we_n
);

    // at most one chip enable low at any time
    p_one_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_ce_n) <= 1);

    // a strobe always sits inside an active chip enable
    p_strobe_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> (mem_ce_n != '1));

    // write and read strobes never overlap
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    // write strobe only with read/not-write low
    p_we_rnw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_rnw);

    // read strobe only with read/not-write high
    p_oe_rnw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_rnw);

    // address holds still through a write strobe
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    // done lasts a single clock
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // an accepted request makes the controller busy
    p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind amem_ctrl amem_ctrl_chk #(.N_CS(N_CS), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .mem_ce_n  (mem_ce_n),
    .mem_rnw   (mem_rnw),
    .mem_addr  (mem_addr),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
);

// File: tb/sim_amem_ctrl.sv
`timescale 1ns/1ps
module sim_amem_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [21:0] req_addr = '0;
    logic [1:0]  req_bank = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rdata;
    logic [15:0] cfg_rs = '0, cfg_rst = '0, cfg_rh = '0;
    logic [15:0] cfg_ws = '0, cfg_wst = '0, cfg_wh = '0;
    logic [3:0]  cfg_ew = '0, cfg_ss = '0;
    logic [3:0]  mem_ce_n;
    logic        mem_rnw;
    logic [1:0]  mem_bank;
    logic [21:0] mem_addr;
    logic        mem_oe_n;
    logic        mem_we_n;
    wire  [15:0] mem_data;
    logic        mem_wait = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] model   [64];
    logic [15:0] exp_mem [64];
    logic [1:0]  cur_cs = '0;
    logic [5:0]  rd_idx;

    always #2 clk = ~clk;

    // memory model drives the bus while the read strobe is low
    assign rd_idx   = {cur_cs, mem_addr[3:0]};
    assign mem_data = !mem_oe_n ? model[rd_idx] : 16'hzzzz;

    amem_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr), .req_bank(req_bank),
        .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .cfg_rd_setup(cfg_rs), .cfg_rd_strobe(cfg_rst), .cfg_rd_hold(cfg_rh),
        .cfg_wr_setup(cfg_ws), .cfg_wr_strobe(cfg_wst), .cfg_wr_hold(cfg_wh),
        .cfg_ext_wait(cfg_ew), .cfg_sel_strobe(cfg_ss),
        .mem_ce_n(mem_ce_n), .mem_rnw(mem_rnw), .mem_bank(mem_bank), .mem_addr(mem_addr),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_data(mem_data), .mem_wait(mem_wait)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // profile of one chip enable: read then write fields, then mode bits
    task automatic set_cfg(input int cs, input int rs, input int rt, input int rh,
                           input int ws, input int wt, input int wh,
                           input logic ew, input logic ss);
        cfg_rs[cs*4 +: 4]  = 4'(rs);
        cfg_rst[cs*4 +: 4] = 4'(rt);
        cfg_rh[cs*4 +: 4]  = 4'(rh);
        cfg_ws[cs*4 +: 4]  = 4'(ws);
        cfg_wst[cs*4 +: 4] = 4'(wt);
        cfg_wh[cs*4 +: 4]  = 4'(wh);
        cfg_ew[cs]         = ew;
        cfg_ss[cs]         = ss;
    endtask

    // one transaction; called at a negedge with the controller idle
    task automatic txn(input logic wr, input int cs, input logic [21:0] a,
                       input logic [1:0] b, input logic [15:0] wd,
                       input int s, input int t, input int h,
                       input logic ss, input logic ew, input int wk);
        int pre = 0, stb = 0, post = 0, celo = 0, cyc = 0;
        int bad_ce = 0, bad_ctl = 0, bad_dat = 0;
        int exp_stb;
        bit seen = 0, strobe, other;
        logic [5:0] idx;
        idx       = {2'(cs), a[3:0]};
        cur_cs    = 2'(cs);
        exp_stb   = (ew && wk > 0) ? wk + 4 : t + 1;
        req_valid = 1'b1; req_write = wr; req_cs = 2'(cs);
        req_addr  = a; req_bank = b; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 200) begin
            strobe = wr ? !mem_we_n : !mem_oe_n;
            other  = wr ? !mem_oe_n : !mem_we_n;
            if (other) bad_ctl++;
            if (strobe) begin stb++; seen = 1; end
            else if (!seen) pre++;
            else post++;
            mem_wait = (wk > 0) && strobe && (stb <= wk);
            if (!mem_ce_n[cs]) celo++;
            if (ss && ((!mem_ce_n[cs]) != strobe)) bad_ce++;
            for (int k = 0; k < 4; k++)
                if (k != cs && !mem_ce_n[k]) bad_ce++;
            if (mem_addr !== a || mem_bank !== b || mem_rnw !== !wr) bad_ctl++;
            if (wr && mem_data !== wd) bad_dat++;
            if (wr && strobe) model[idx] = mem_data;
            cyc++;
            @(negedge clk);
        end
        mem_wait = 1'b0;
        if (wr) begin
            exp_mem[idx] = wd;
            chk("R2 write setup periods", pre, s + 1);
            chk(ew ? "R7 write strobe periods" : "R3 write strobe periods", stb, exp_stb);
            chk("R4 write hold periods", post, h + 1);
            chk("R10 write data driven all cycle", bad_dat, 0);
        end else begin
            chk("R5 read setup periods", pre, s + 1);
            chk(ew ? "R7 read strobe periods" : "R5 read strobe periods", stb, exp_stb);
            chk("R5 read hold periods", post, h + 1);
            chk("R9 R10 read data", int'(rdata), int'(exp_mem[idx]));
        end
        chk("R6 ce low periods", celo, ss ? exp_stb : (pre + stb + post));
        chk("R6 ce window and other enables", bad_ce, 0);
        chk("R2 R5 addr bank rnw stable, other strobe idle", bad_ctl, 0);
        chk("R4 done seen", int'(done), 1);
        chk("R11 ready with done", int'(req_ready), 1);
    endtask

    // watchdog
    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            model[i]   = 16'hA500 ^ 16'(i * 37);
            exp_mem[i] = 16'hA500 ^ 16'(i * 37);
        end
        repeat (3) @(negedge clk);
        chk("R1 ce_n in reset", int'(mem_ce_n), 15);
        chk("R1 strobes in reset", int'({mem_oe_n, mem_we_n}), 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ce_n after reset", int'(mem_ce_n), 15);
        chk("R1 done after reset", int'(done), 0);
        chk("R11 ready after reset", int'(req_ready), 1);

        // sweep over setup/strobe/hold 0..2 and both chip-enable modes
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 3; s++)
                for (int t = 0; t < 3; t++)
                    for (int h = 0; h < 3; h++) begin
                        int cs = (s + t + h + m) % 4;
                        logic [21:0] a = 22'(s * 9 + t * 3 + h) ^ 22'h2A_5000;
                        logic [15:0] wd = 16'(16'h1234 * (s + 1) + t * 77 + h * 5 + m);
                        set_cfg(cs, h, s, t, s, t, h, 1'b0, 1'(m));
                        txn(1'b1, cs, a, 2'(s + h), wd, s, t, h, 1'(m), 1'b0, 0);
                        txn(1'b0, cs, a, 2'(s + h), 16'h0, h, s, t, 1'(m), 1'b0, 0);
                    end

        // all fields at their largest value
        set_cfg(3, 15, 15, 15, 15, 15, 15, 1'b0, 1'b0);
        txn(1'b1, 3, 22'h3F_FFFF, 2'd3, 16'hFFFF, 15, 15, 15, 1'b0, 1'b0, 0);
        txn(1'b0, 3, 22'h3F_FFFF, 2'd3, 16'h0, 15, 15, 15, 1'b0, 1'b0, 0);

        // R12: distinct profiles per chip enable, used alternately
        set_cfg(1, 1, 4, 2, 2, 3, 1, 1'b0, 1'b0);
        set_cfg(2, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1);
        txn(1'b1, 1, 22'h00_0007, 2'd1, 16'hBEEF, 2, 3, 1, 1'b0, 1'b0, 0);
        txn(1'b1, 2, 22'h00_0007, 2'd2, 16'hCAFE, 0, 0, 0, 1'b1, 1'b0, 0);
        txn(1'b0, 1, 22'h00_0007, 2'd1, 16'h0, 1, 4, 2, 1'b0, 1'b0, 0);
        txn(1'b0, 2, 22'h00_0007, 2'd2, 16'h0, 0, 0, 0, 1'b1, 1'b0, 0);

        // R7: WAIT runs of several lengths with extended wait on
        for (int k = 1; k < 7; k += 2) begin
            set_cfg(0, 1, 1, 0, 0, 2, 1, 1'b1, 1'(k > 3));
            txn(1'b1, 0, 22'(k), 2'd0, 16'(16'h7700 + k), 0, 2, 1, 1'(k > 3), 1'b1, k);
            txn(1'b0, 0, 22'(k), 2'd0, 16'h0, 1, 1, 0, 1'(k > 3), 1'b1, k);
        end

        // R8: WAIT held high with extended wait off changes nothing
        set_cfg(0, 0, 2, 1, 1, 1, 0, 1'b0, 1'b0);
        txn(1'b1, 0, 22'h15, 2'd1, 16'h5A5A, 1, 1, 0, 1'b0, 1'b0, 5);
        txn(1'b0, 0, 22'h15, 2'd1, 16'h0, 0, 2, 1, 1'b0, 1'b0, 5);

        @(negedge clk);
        chk("R1 idle enables after traffic", int'(mem_ce_n), 15);
        summary();
    end

endmodule